// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts conditional branch direction from two things: low bits of the branch address, and a short record of how the most recently resolved branches went. The record covers every branch, not only the one being predicted. Each address slot keeps one small saturating counter for every possible history pattern. The current history picks which of those counters answers. Because of this, a branch can learn a different answer for each pattern of outcomes that came before it.

A fetch stage presents a PC and receives a taken/not-taken guess in the same cycle. It also receives the history pattern used for that guess and carries it down the pipe. When the branch resolves, the back end presents the PC, the real outcome and the carried history. The selected counter then moves one step toward the outcome, and the outcome is shifted into the global history. The history width m, the counter width n, the number of address-index bits and the position of the index within the PC are all parameters. The default is m = 2, n = 2.

Top module: `corr_bp`

## Requirements
- R1: After reset, the global history is all zeros and every counter is zero, so every PC predicts not taken.
- R2: `predTaken` is the most significant bit of the counter at table address {PC bits [PC_LSB +: IDX_BITS], current history}. It responds combinationally to `predPc` in the same cycle. `predHist` always shows the current history.
- R3: On an update, the selected counter increments when `updTaken` is 1 and decrements when it is 0. It holds at 0 and at 2^n−1 instead of wrapping.
- R4: The counter written on update is chosen by `updHist`, not by the current history.
- R5: Every update shifts the history left by one with `updTaken` entering at bit 0, whatever the PC.
- R6: A cycle without `updValid` changes neither the history nor any counter.
- R7: PC bits outside the index field are ignored. Two PCs that differ only there share a counter.
- R8: When predict and update address the same counter in one cycle, the prediction shows the value before the update.
- R9: With m = 1 and n = 1, two branches whose outcomes alternate T, NT, T, NT in lockstep each mispredict only on their first execution.
- R10: With m = 5 and n = 1, an inner branch going T, T, T, T, NT inside an always-taken outer branch is predicted without error in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | PC of the branch to predict |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | HIST_BITS | History used for this prediction |
| updValid | input | 1 | A resolved branch is presented |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updHist | input | HIST_BITS | History captured at predict time |

## Verification
The assertions check the following on every cycle:
- the history shift on each update, and that the history is zero right after reset;
- that the history and the prediction hold steady when no update arrives;
- that the control never asks for an increment and a decrement together, and never writes without an update.

Saturation, the choice of counter through `updHist`, address aliasing and read-before-write can only be seen by comparing predictions against an arithmetic model across directed and pseudo-random sweeps. The same is true of the learning behaviour in the (1,1) lockstep case and the (5,1) nested-loop case.

// File: rtl/corr_bp_pkg.sv
`timescale 1ns/1ps
package corr_bp_pkg;
  // Strobes from control to datapath for one update cycle
  typedef struct packed {
    logic wrEn;       // write the selected counter
    logic cntUp;      // step toward taken
    logic cntDown;    // step toward not taken
    logic histShift;  // shift the outcome into the global history
  } bpStrobes_t;
endpackage

// File: rtl/corr_bp_datapath.sv
`timescale 1ns/1ps
module corr_bp_datapath
  import corr_bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      predPc,
  input  logic [PC_W-1:0]      updPc,
  input  logic [HIST_BITS-1:0] updHist,
  input  logic                 updTaken,
  input  bpStrobes_t           strb,
  output logic [CTR_BITS-1:0]  predCtr,
  output logic [CTR_BITS-1:0]  updCtr,
  output logic [HIST_BITS-1:0] ghr
);
  localparam int ADDR_W  = IDX_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << ADDR_W;

  logic [CTR_BITS-1:0]  ctrTab [ENTRIES];
  logic [ADDR_W-1:0]    predAddr;
  logic [ADDR_W-1:0]    updAddr;
  logic [CTR_BITS-1:0]  ctrNext;
  logic [HIST_BITS-1:0] ghrNext;
  logic                 unusedPcBits;

  // Table address: PC index field above the history bits
  assign predAddr = {predPc[PC_LSB +: IDX_BITS], ghr};
  assign updAddr  = {updPc[PC_LSB +: IDX_BITS], updHist};
  assign unusedPcBits = ^{predPc, updPc};

  assign predCtr = ctrTab[predAddr];
  assign updCtr  = ctrTab[updAddr];

  always_comb begin
    ctrNext = updCtr;
    if (strb.cntUp)
      ctrNext = updCtr + 1'b1;
    else if (strb.cntDown)
      ctrNext = updCtr - 1'b1;
  end

  generate
    if (HIST_BITS == 1) begin : g_hist1
      always_comb ghrNext = updTaken;
    end else begin : g_histN
      always_comb ghrNext = {ghr[HIST_BITS-2:0], updTaken};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctrTab[i] <= '0;
      ghr <= '0;
    end else begin
      if (strb.wrEn) ctrTab[updAddr] <= ctrNext;
      if (strb.histShift) ghr <= ghrNext;
    end
  end
endmodule

// File: rtl/corr_bp_control.sv
`timescale 1ns/1ps
module corr_bp_control
  import corr_bp_pkg::*;
#(
  parameter int CTR_BITS = 2
) (
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [CTR_BITS-1:0] predCtr,
  input  logic [CTR_BITS-1:0] updCtr,
  output bpStrobes_t          strb,
  output logic                predTaken
);
  localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
  localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

  logic atTop;
  logic atBottom;

  assign atTop     = (updCtr == CTR_MAX);
  assign atBottom  = (updCtr == CTR_MIN);
  assign predTaken = predCtr[CTR_BITS-1];

  always_comb begin
    strb           = '0;
    strb.histShift = updValid;
    strb.cntUp     = updValid &&  updTaken && !atTop;
    strb.cntDown   = updValid && !updTaken && !atBottom;
    strb.wrEn      = strb.cntUp || strb.cntDown;
  end
endmodule

// File: rtl/corr_bp.sv
`timescale 1ns/1ps
module corr_bp
  import corr_bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      predPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predHist,
  input  logic                 updValid,
  input  logic [PC_W-1:0]      updPc,
  input  logic                 updTaken,
  input  logic [HIST_BITS-1:0] updHist
);
  bpStrobes_t          strb;
  logic [CTR_BITS-1:0] predCtr;
  logic [CTR_BITS-1:0] updCtr;

  corr_bp_control #(.CTR_BITS(CTR_BITS)) u_ctl (
    .updValid (updValid),
    .updTaken (updTaken),
    .predCtr  (predCtr),
    .updCtr   (updCtr),
    .strb     (strb),
    .predTaken(predTaken)
  );

  corr_bp_datapath #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS),
    .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .predPc  (predPc),
    .updPc   (updPc),
    .updHist (updHist),
    .updTaken(updTaken),
    .strb    (strb),
    .predCtr (predCtr),
    .updCtr  (updCtr),
    .ghr     (predHist)
  );
endmodule

// File: rtl/corr_bp_chk.sv
`timescale 1ns/1ps
module corr_bp_chk
  import corr_bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PC_W-1:0]      predPc,
  input logic                 predTaken,
  input logic [HIST_BITS-1:0] predHist,
  input logic                 updValid,
  input logic                 updTaken,
  input bpStrobes_t           strb
);
  // R1
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> predHist == '0);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updValid |=> predHist == HIST_BITS'({$past(predHist), $past(updTaken)}));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |=> $stable(predHist));

  // R6
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |=> ($stable(predPc) -> $stable(predTaken)));

  // R3
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.cntUp, strb.cntDown}));

  // R6
  write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn || strb.histShift) |-> updValid);
endmodule

bind corr_bp corr_bp_chk #(.PC_W(PC_W), .HIST_BITS(HIST_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .predPc   (predPc),
  .predTaken(predTaken),
  .predHist (predHist),
  .updValid (updValid),
  .updTaken (updTaken),
  .strb     (strb)
);

// File: tb/corr_bp_test.sv
`timescale 1ns/1ps
module corr_bp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // ---------------- default (2,2) instance ----------------
  logic [31:0] predPc = '0, updPc = '0;
  logic        updValid = 1'b0, updTaken = 1'b0;
  logic [1:0]  updHist = '0;
  logic        predTaken;
  logic [1:0]  predHist;

  corr_bp uut (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .predHist(predHist), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updHist(updHist));

  // ---------------- (1,1) instance ----------------
  logic [31:0] cPc = '0, cUpc = '0;
  logic        cUv = 1'b0, cUt = 1'b0, cUh = 1'b0;
  logic        cPred;
  logic        cHist;

  corr_bp #(.IDX_BITS(2), .HIST_BITS(1), .CTR_BITS(1)) uutCor (
    .clk(clk), .rst_n(rst_n), .predPc(cPc), .predTaken(cPred),
    .predHist(cHist), .updValid(cUv), .updPc(cUpc),
    .updTaken(cUt), .updHist(cUh));

  // ---------------- (5,1) instance ----------------
  logic [31:0] lPc = '0, lUpc = '0;
  logic        lUv = 1'b0, lUt = 1'b0;
  logic [4:0]  lUh = '0;
  logic        lPred;
  logic [4:0]  lHist;

  corr_bp #(.IDX_BITS(2), .HIST_BITS(5), .CTR_BITS(1)) uutLoop (
    .clk(clk), .rst_n(rst_n), .predPc(lPc), .predTaken(lPred),
    .predHist(lHist), .updValid(lUv), .updPc(lUpc),
    .updTaken(lUt), .updHist(lUh));

  // ---------------- model of the (2,2) instance ----------------
  int mdl [64];
  int ghrM = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic int addrOf(logic [31:0] pc, int h);
    return ((int'(pc[5:2])) << 2) | (h & 3);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic checkV(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle on the (2,2) instance; h < 0 means use the current history
  task automatic cyc(input logic [31:0] pPc, input logic v, input logic [31:0] uPc,
                     input logic t, input int h, input string tag);
    int hu;
    @(negedge clk);
    hu = (h < 0) ? ghrM : h;
    predPc = pPc; updValid = v; updPc = uPc; updTaken = t; updHist = 2'(hu);
    #1;
    check(predTaken, mdl[addrOf(pPc, ghrM)] >= 2, tag);
    checkV(int'(predHist), ghrM, tag);
    @(posedge clk);
    if (v) begin
      if (t && mdl[addrOf(uPc, hu)] < 3) mdl[addrOf(uPc, hu)]++;
      if (!t && mdl[addrOf(uPc, hu)] > 0) mdl[addrOf(uPc, hu)]--;
      ghrM = ((ghrM << 1) | int'(t)) & 3;
    end
  endtask

  function automatic logic [31:0] nextRng(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // ---------------- (2,2) instance scenarios ----------------
  task automatic runMain();
    logic [31:0] pcA = 32'h0000_0010;  // index 4
    logic [31:0] pcB = 32'h0000_0024;  // index 9
    // R1: all index values predict not taken, history zero
    for (int i = 0; i < 16; i++) cyc(32'(i << 2), 1'b0, '0, 1'b0, 0, "R1 reset state");
    // R3: five taken steps saturate at 3, readback with history 3
    for (int i = 0; i < 5; i++) cyc(pcA, 1'b1, pcA, 1'b1, 3, "R3 count up");
    cyc(pcA, 1'b0, '0, 1'b0, 0, "R3 saturated high");
    cyc(pcA, 1'b1, pcA, 1'b0, 3, "R3 one step down");
    cyc(pcA, 1'b1, pcB, 1'b1, 0, "R5 any pc shifts");
    cyc(pcA, 1'b1, pcB, 1'b1, 0, "R5 any pc shifts");
    cyc(pcA, 1'b0, '0, 1'b0, 0, "R3 still taken at 2");
    for (int i = 0; i < 4; i++) cyc(pcA, 1'b1, pcA, 1'b0, 3, "R3 count down");
    cyc(pcA, 1'b1, pcB, 1'b1, 0, "R5 refill history");
    cyc(pcA, 1'b1, pcB, 1'b1, 0, "R5 refill history");
    cyc(pcA, 1'b0, '0, 1'b0, 0, "R3 saturated low");
    cyc(pcA, 1'b1, pcA, 1'b1, 3, "R3 up from floor");
    cyc(pcA, 1'b0, '0, 1'b0, 0, "R3 weak not taken");
    // R8: predict and update the same counter in the same cycle
    cyc(pcA, 1'b1, pcA, 1'b1, 3, "R8 read before write");
    cyc(pcA, 1'b0, '0, 1'b0, 0, "R8 new value visible");
    // R4: write through a history unlike the current one
    cyc(pcB, 1'b1, pcB, 1'b1, 1, "R4 stale history");
    cyc(pcB, 1'b1, pcB, 1'b1, 1, "R4 stale history");
    cyc(pcB, 1'b1, pcB, 1'b0, 0, "R4 stale history");
    cyc(pcB, 1'b0, '0, 1'b0, 0, "R4 readback h1");
    // R7: aliases of pcA differing outside the index field
    cyc(32'hFFFF_FFD3, 1'b1, 32'hA5A5_A412, 1'b1, -1, "R7 alias");
    cyc(32'h8000_0013, 1'b1, 32'h7000_0011, 1'b1, -1, "R7 alias");
    cyc(32'h0F00_0012, 1'b0, '0, 1'b0, 0, "R7 alias read");
    // R6: idle cycles change nothing
    for (int i = 0; i < 20; i++) cyc(32'(i * 4 + 1), 1'b0, 32'(i * 8), 1'b1, 2, "R6 idle");
    // R2 R4 R5 R8: pseudo-random sweep
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, b;
      rng = nextRng(rng); a = rng;
      rng = nextRng(rng); b = rng;
      if (b[7]) b = a;
      cyc(a, rng[3] | rng[4], b, rng[9], rng[12] ? -1 : int'(rng[14:13]), "R2 sweep");
    end
  endtask

  // ---------------- (1,1) lockstep scenario: R9 ----------------
  task automatic runCor();
    logic [31:0] pcs [2];
    pcs[0] = 32'h100; pcs[1] = 32'h104;
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 2; b++) begin
        logic act, p;
        act = (k % 2 == 0);
        @(negedge clk);
        cPc = pcs[b];
        #1;
        p = cPred;
        cUv = 1'b1; cUpc = pcs[b]; cUt = act; cUh = cHist;
        if (k == 0) check(p, 1'b0, "R9 first run not taken");
        else check(p, act, "R9 correlated correct");
        @(posedge clk);
      end
    end
    @(negedge clk); cUv = 1'b0;
  endtask

  // ---------------- (5,1) nested loop: R10 ----------------
  task automatic runLoop();
    logic [31:0] inner = 32'h200, outer = 32'h20C;
    for (int it = 0; it < 20; it++) begin
      for (int s = 0; s < 6; s++) begin
        logic act, p;
        logic [31:0] pc;
        pc  = (s < 5) ? inner : outer;
        act = (s != 4);
        @(negedge clk);
        lPc = pc;
        #1;
        p = lPred;
        lUv = 1'b1; lUpc = pc; lUt = act; lUh = lHist;
        if (it >= 8) check(p, act, "R10 loop steady state");
        @(posedge clk);
      end
    end
    @(negedge clk); lUv = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    runCor();
    runLoop();
    runMain();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule